// File: doc/BRIEF.md
# Eight-Entry Store Buffer with Pairwise Age Replacement

This block absorbs CPU stores into eight fully associative entries. Each entry holds a data word (48 data bits plus two parity bits, generated outside) and a 16-bit tag. The tag is a 15-bit word address with bit 15 set when the address is unmapped. A tag of zero means the entry is empty. Loads that match a buffered tag are answered from the buffer in the cycle they are accepted. Loads that miss are left to the memory path outside this block and allocate nothing.

Replacement is driven by a triangular precedence matrix with one bit per unordered pair of entries. Whenever a store lands in the entry that is currently oldest, the block picks a new oldest entry and spends the next cycle writing that entry back through a single memory write port, then empties it. Stores to a small reserved window of unmapped addresses are not buffered. Instead, each one advances a drain counter that evicts entries one by one, and it resets the age order part-way through the sequence. The CPU side uses a valid/ready pair, and ready drops for exactly the eviction cycle.

Top module: `wbuf_top`

## Requirements
- R1: After reset the buffer is empty. reqReady is high, memWe is low, every load misses, and the age order runs from entry 0 (oldest) to entry 7 (newest).
- R2: A store whose low 15 address bits are all zero is accepted and dropped, whatever bit 15 is. It fills no entry, causes no stall, and leaves the drain counter unchanged.
- R3: A store whose full 16-bit tag equals that of a non-empty entry overwrites that entry's word, and a later load returns the new word. If that entry was not the oldest, there is no stall.
- R4: A store that misses takes the oldest entry. Whenever the entry written was the oldest, it becomes newest, a new oldest entry is chosen, and reqReady is low for exactly the following cycle. That cycle is the eviction of the new oldest entry.
- R5: Evicting a non-empty entry raises memWe for that one cycle. memAddr carries the entry's full 16-bit tag and memWdata its word, and the entry becomes empty.
- R6: Age is kept as 28 pairwise bits (bit set: the lower-numbered entry of the pair is newer), numbered row by row from pair (0,1). The oldest entry is the lowest-numbered entry that is newer than no other entry. A load hit on an entry that is not the oldest makes it newest. A load hit on the oldest entry leaves the order alone.
- R7: An accepted load that hits raises loadHit in its accept cycle, with loadData equal to the buffered word. A load that misses keeps loadHit low and changes no entry.
- R8: A store with bit 15 set and low bits 1 to 7 is not buffered. With a drain count c before it, counts 1 to 8 make the oldest entry newest, choose a new oldest entry and evict it in a stall cycle. Counts 0 and 9 do nothing further. The count then increments and saturates at 9. With bit 15 clear, addresses 1 to 7 are ordinary buffered stores.
- R9: A drain step taken at count 7 evicts as in R8 and then resets the age order, so entry 0 is oldest again.
- R10: Every buffered store (not dropped, not in the window) resets the drain count to 0. Loads leave it unchanged.
- R11: Evicting an empty entry produces no memory write, but the stall cycle still occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | CPU request present |
| reqReady | output | 1 | Request accepted this cycle when high |
| reqWrite | input | 1 | 1 store, 0 load |
| reqAddr | input | 16 | Tag: bit 15 unmapped flag, bits 14:0 word address |
| reqWdata | input | 50 | Store word with parity |
| loadHit | output | 1 | Accepted load matched a buffered entry |
| loadData | output | 50 | Word of the matching entry |
| memWe | output | 1 | Memory write strobe for an eviction |
| memAddr | output | 16 | Tag of the evicted entry |
| memWdata | output | 50 | Word of the evicted entry |

## Verification
The checker assumes that reset is held for at least one rising edge and that reqAddr and reqWrite carry known values whenever reqValid is high. The eviction properties also rely on the only way into a stall being an accepted store. The bench drives every request on the falling edge and keeps reqValid high for a single accepted cycle. It waits on reqReady before presenting the next request, so a request is never left pending across a stall. This keeps each store's eviction cycle free of competing traffic and lets the drain sequence, the order reset at count 7 and the non-refreshing hit on the oldest entry be traced against an ordered-list model.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  localparam int NUM_ENT = 8;
  localparam int IDX_W   = $clog2(NUM_ENT);
  localparam int PAIRS   = NUM_ENT * (NUM_ENT - 1) / 2;
  localparam int ADDR_W  = 15;
  localparam int TAG_W   = ADDR_W + 1;
  localparam int DATA_W  = 50;
  localparam int WIN_LO  = 1;
  localparam int WIN_HI  = 7;
  localparam int CNT_MAX = NUM_ENT + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int CLR_AT  = NUM_ENT - 1;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic             flushEn;
    logic [IDX_W-1:0] flushIdx;
  } dpStrobe_t;

  // position of pair (n,m), n<m, counted row by row
  function automatic int pairBit(int n, int m);
    return n * (NUM_ENT - 1) - (n * (n - 1)) / 2 + (m - n - 1);
  endfunction

  function automatic logic [PAIRS-1:0] winMask(int i);
    logic [PAIRS-1:0] r = '0;
    for (int m = 0; m < NUM_ENT; m++)
      if (m > i) r[pairBit(i, m)] = 1'b1;
    return r;
  endfunction

  function automatic logic [PAIRS-1:0] loseMask(int i);
    logic [PAIRS-1:0] r = '0;
    for (int n = 0; n < NUM_ENT; n++)
      if (n < i) r[pairBit(n, i)] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/wbuf_dpath.sv
module wbuf_dpath
  import wbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [TAG_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              hit,
  output logic [IDX_W-1:0]  hitIdx,
  output logic [DATA_W-1:0] rdData,
  output logic              memWe,
  output logic [TAG_W-1:0]  memAddr,
  output logic [DATA_W-1:0] memWdata
);
  logic [TAG_W-1:0]  tagQ  [NUM_ENT];
  logic [DATA_W-1:0] dataQ [NUM_ENT];
  logic [NUM_ENT-1:0] matchVec;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    assign matchVec[g] = (tagQ[g] != '0) && (tagQ[g] == reqAddr);

    always_ff @(posedge clk) begin
      if (!rstN) tagQ[g] <= '0;
      else if (stb.wrEn && stb.wrIdx == IDX_W'(g)) tagQ[g] <= reqAddr;
      else if (stb.flushEn && stb.flushIdx == IDX_W'(g)) tagQ[g] <= '0;
    end

    always_ff @(posedge clk) begin
      if (stb.wrEn && stb.wrIdx == IDX_W'(g)) dataQ[g] <= reqWdata;
    end
  end

  always_comb begin
    hitIdx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--)
      if (matchVec[i]) hitIdx = IDX_W'(i);
  end

  assign hit      = |matchVec;
  assign rdData   = dataQ[hitIdx];
  assign memWe    = stb.flushEn && (tagQ[stb.flushIdx] != '0);
  assign memAddr  = tagQ[stb.flushIdx];
  assign memWdata = dataQ[stb.flushIdx];
endmodule

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
  import wbuf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [TAG_W-1:0] reqAddr,
  input  logic             hit,
  input  logic [IDX_W-1:0] hitIdx,
  output logic             reqReady,
  output logic             loadHit,
  output dpStrobe_t        stb
);
  logic [PAIRS-1:0] ageMat, matTouched;
  logic [PAIRS-1:0] winM  [NUM_ENT];
  logic [PAIRS-1:0] loseM [NUM_ENT];
  logic [IDX_W-1:0] oldest, newOld, selIdx, touchIdx, flushIdxQ;
  logic [CNT_W-1:0] flushCnt;
  logic             flushPend;
  logic [ADDR_W-1:0] lo;
  logic accept, isZero, isWin, normSt, winSt, ldHit, stepOn;
  logic touchEn, needFlush, clrNow;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_mask
    assign winM[g]  = winMask(g);
    assign loseM[g] = loseMask(g);
  end

  always_comb begin
    lo        = reqAddr[ADDR_W-1:0];
    accept    = reqValid && !flushPend;
    isZero    = (lo == '0);
    isWin     = reqAddr[ADDR_W] && (lo >= ADDR_W'(WIN_LO)) && (lo <= ADDR_W'(WIN_HI));
    normSt    = accept && reqWrite && !isZero && !isWin;
    winSt     = accept && reqWrite && isWin;
    ldHit     = accept && !reqWrite && hit;
    stepOn    = winSt && (flushCnt >= CNT_W'(1)) && (flushCnt <= CNT_W'(NUM_ENT));
    selIdx    = hit ? hitIdx : oldest;
    touchIdx  = stepOn ? oldest : (normSt ? selIdx : hitIdx);
    touchEn   = normSt || stepOn || (ldHit && hitIdx != oldest);
    needFlush = stepOn || (normSt && selIdx == oldest);
    clrNow    = stepOn && (flushCnt == CNT_W'(CLR_AT));
    matTouched = (ageMat & ~loseM[touchIdx]) | winM[touchIdx];
    newOld = oldest;
    for (int i = NUM_ENT - 1; i >= 0; i--)
      if (((matTouched & winM[i]) == '0) && ((matTouched & loseM[i]) == loseM[i]))
        newOld = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ageMat    <= '0;
      oldest    <= '0;
      flushCnt  <= '0;
      flushPend <= 1'b0;
      flushIdxQ <= '0;
    end else begin
      flushPend <= 1'b0;
      if (touchEn) ageMat <= clrNow ? '0 : matTouched;
      if (needFlush) begin
        oldest    <= clrNow ? '0 : newOld;
        flushPend <= 1'b1;
        flushIdxQ <= newOld;
      end
      if (normSt) flushCnt <= '0;
      else if (winSt && flushCnt != CNT_W'(CNT_MAX)) flushCnt <= flushCnt + 1'b1;
    end
  end

  assign reqReady     = !flushPend;
  assign loadHit      = ldHit;
  assign stb.wrEn     = normSt;
  assign stb.wrIdx    = selIdx;
  assign stb.flushEn  = flushPend;
  assign stb.flushIdx = flushIdxQ;
endmodule

// File: rtl/wbuf_top.sv
module wbuf_top
  import wbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [TAG_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              loadHit,
  output logic [DATA_W-1:0] loadData,
  output logic              memWe,
  output logic [TAG_W-1:0]  memAddr,
  output logic [DATA_W-1:0] memWdata
);
  dpStrobe_t        stb;
  logic             hit;
  logic [IDX_W-1:0] hitIdx;

  wbuf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .hit(hit), .hitIdx(hitIdx),
    .reqReady(reqReady), .loadHit(loadHit), .stb(stb)
  );

  wbuf_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .hit(hit), .hitIdx(hitIdx), .rdData(loadData),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );
endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk
  import wbuf_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqWrite,
  input logic [TAG_W-1:0]  reqAddr,
  input logic              loadHit,
  input logic              memWe,
  input logic [TAG_W-1:0]  memAddr
);
  // R4: eviction happens only while requests are held off
  a_r4_write_in_stall: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !reqReady);

  // R4: the stall lasts a single cycle
  a_r4_stall_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |=> reqReady);

  // R4: a stall follows an accepted store
  a_r4_stall_after_store: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |-> $past(reqValid && reqReady && reqWrite));

  // R5, R11: an eviction write never carries an empty tag
  a_r5_tag_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memAddr != '0);

  // R2: a dropped store causes no stall
  a_r2_drop_no_stall: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite && reqAddr[ADDR_W-1:0] == '0) |=> reqReady);

  // R7: hits are reported only for accepted loads of a non-zero address
  a_r7_hit_on_load: assert property (@(posedge clk) disable iff (!rstN)
    loadHit |-> (reqValid && reqReady && !reqWrite && reqAddr[ADDR_W-1:0] != '0));
endmodule

bind wbuf_top wbuf_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqWrite(reqWrite), .reqAddr(reqAddr), .loadHit(loadHit),
  .memWe(memWe), .memAddr(memAddr)
);

// File: tb/wbuf_top_test.sv
`timescale 1ns/1ps
module wbuf_top_test;
  import wbuf_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqWrite = 1'b0;
  logic [TAG_W-1:0]  reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic              reqReady, loadHit, memWe;
  logic [DATA_W-1:0] loadData, memWdata;
  logic [TAG_W-1:0]  memAddr;

  always #2 clk = ~clk;

  wbuf_top uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .loadHit(loadHit), .loadData(loadData),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  // ordered-list reference: ord[0] oldest, ord[7] newest
  int                ord  [8];
  logic [TAG_W-1:0]  mTag [8];
  logic [DATA_W-1:0] mDat [8];
  int                mCnt;

  typedef struct packed {
    logic [1:0]        op;   // 0 load, 1 store, 2 reset
    logic [TAG_W-1:0]  addr;
    logic [DATA_W-1:0] data;
  } vec_t;

  localparam int NV = 56;
  localparam vec_t VECS [NV] = '{
    // phase A: fill, then the eighth store evicts the first (R4, R5, R11)
    '{2'd1, 16'h0011, 50'h1_0000_0000_0011}, '{2'd1, 16'h0012, 50'h1_0000_0000_0012},
    '{2'd1, 16'h0013, 50'h1_0000_0000_0013}, '{2'd1, 16'h0014, 50'h1_0000_0000_0014},
    '{2'd1, 16'h0015, 50'h1_0000_0000_0015}, '{2'd1, 16'h0016, 50'h1_0000_0000_0016},
    '{2'd1, 16'h0017, 50'h1_0000_0000_0017}, '{2'd1, 16'h0018, 50'h1_0000_0000_0018},
    '{2'd0, 16'h0011, 50'h0},                // R7 evicted word misses
    '{2'd0, 16'h0013, 50'h0},                // R7 hit, R6 refresh
    '{2'd1, 16'h0014, 50'h2_AAAA_5555_0014}, // R3 overwrite
    '{2'd0, 16'h0014, 50'h0},                // R3 new word
    '{2'd1, 16'h0000, 50'h3_0000_0000_0000}, // R2 dropped
    '{2'd1, 16'h8000, 50'h3_0000_0000_8000}, // R2 dropped, flag set
    '{2'd0, 16'h0000, 50'h0},
    '{2'd1, 16'h0019, 50'h1_0000_0000_0019}, // R4 evicts 0012
    '{2'd0, 16'h0012, 50'h0},
    '{2'd1, 16'h0003, 50'h1_0000_0000_0003}, // R8 mapped 1..7 is buffered
    '{2'd1, 16'h8008, 50'h1_0000_0000_8008}, // R8 just outside the window
    '{2'd0, 16'h0003, 50'h0},
    // phase B: drain sequence with an order reset (R8, R9, R6)
    '{2'd2, 16'h0000, 50'h0},
    '{2'd1, 16'h0021, 50'h2_0000_0000_0021}, '{2'd1, 16'h0022, 50'h2_0000_0000_0022},
    '{2'd1, 16'h0023, 50'h2_0000_0000_0023}, '{2'd1, 16'h0024, 50'h2_0000_0000_0024},
    '{2'd1, 16'h0025, 50'h2_0000_0000_0025}, '{2'd1, 16'h0026, 50'h2_0000_0000_0026},
    '{2'd1, 16'h0027, 50'h2_0000_0000_0027},
    '{2'd0, 16'h0021, 50'h0},
    '{2'd1, 16'h8003, 50'h0}, '{2'd1, 16'h8003, 50'h0}, '{2'd1, 16'h8003, 50'h0},
    '{2'd1, 16'h8003, 50'h0}, '{2'd1, 16'h8003, 50'h0},
    '{2'd0, 16'h0021, 50'h0},
    '{2'd1, 16'h8003, 50'h0}, '{2'd1, 16'h8003, 50'h0},
    '{2'd1, 16'h8003, 50'h0},                // R9 count 7 resets order
    '{2'd0, 16'h0021, 50'h0},                // R6 hit on oldest, no refresh
    '{2'd1, 16'h0030, 50'h2_0000_0000_0030}, // takes entry 0
    '{2'd0, 16'h0021, 50'h0},                // R6 now misses
    '{2'd1, 16'h8005, 50'h0},                // R10 count back at 0
    '{2'd1, 16'h8001, 50'h0}, '{2'd1, 16'h8007, 50'h0}, '{2'd1, 16'h8002, 50'h0},
    '{2'd0, 16'h0030, 50'h0},                // R10 load keeps count
    '{2'd1, 16'h8001, 50'h0}, '{2'd1, 16'h8001, 50'h0}, '{2'd1, 16'h8001, 50'h0},
    '{2'd1, 16'h8001, 50'h0}, '{2'd1, 16'h8001, 50'h0}, '{2'd1, 16'h8001, 50'h0},
    '{2'd1, 16'h8001, 50'h0},                // R8 saturated, nothing
    '{2'd1, 16'h8001, 50'h0},
    '{2'd1, 16'h0031, 50'h2_0000_0000_0031},
    '{2'd0, 16'h0031, 50'h0}
  };

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void modelReset();
    for (int k = 0; k < 8; k++) begin
      ord[k] = k; mTag[k] = '0; mDat[k] = '0;
    end
    mCnt = 0;
  endfunction

  function automatic void touch(int i);
    int p = 0;
    for (int k = 0; k < 8; k++) if (ord[k] == i) p = k;
    for (int k = 0; k < 7; k++) if (k >= p) ord[k] = ord[k + 1];
    ord[7] = i;
  endfunction

  function automatic int findTag(logic [TAG_W-1:0] a);
    int r = -1;
    for (int k = 0; k < 8; k++) if (mTag[k] != '0 && mTag[k] == a) r = k;
    return r;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; reqValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    modelReset();
    check(reqReady == 1'b1, "R1", "ready after reset", 64'(reqReady), 64'd1);
    check(memWe == 1'b0, "R1", "memWe after reset", 64'(memWe), 64'd0);
  endtask

  task automatic doStore(logic [TAG_W-1:0] a, logic [DATA_W-1:0] d);
    bit expStall = 0, expWe = 0;
    logic [TAG_W-1:0] expA = '0;
    logic [DATA_W-1:0] expD = '0;
    int idx, n;
    string req = "R4";
    if (a[ADDR_W-1:0] == '0) begin
      req = "R2";
    end else if (a[ADDR_W] && a[ADDR_W-1:0] <= 15'd7) begin
      req = (mCnt == 7) ? "R9" : "R8";
      if (mCnt >= 1 && mCnt <= 8) begin
        touch(ord[0]);
        n = ord[0];
        expStall = 1; expWe = (mTag[n] != '0); expA = mTag[n]; expD = mDat[n];
        mTag[n] = '0;
        if (mCnt == 7) for (int k = 0; k < 8; k++) ord[k] = k;
      end
      if (mCnt < 9) mCnt++;
    end else begin
      mCnt = 0;
      idx = findTag(a);
      if (idx < 0) idx = ord[0];
      else req = "R3";
      mTag[idx] = a; mDat[idx] = d;
      if (idx == ord[0]) begin
        touch(idx);
        n = ord[0];
        expStall = 1; expWe = (mTag[n] != '0); expA = mTag[n]; expD = mDat[n];
        mTag[n] = '0;
        req = expWe ? "R5" : "R11";
      end else touch(idx);
    end
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == !expStall, req, "stall", 64'(reqReady), 64'(!expStall));
    check(memWe == expWe, req, "memWe", 64'(memWe), 64'(expWe));
    if (expWe && memWe) begin
      check(memAddr == expA, req, "memAddr", 64'(memAddr), 64'(expA));
      check(memWdata == expD, req, "memWdata", 64'(memWdata), 64'(expD));
    end
  endtask

  task automatic doLoad(logic [TAG_W-1:0] a);
    int idx = (a[ADDR_W-1:0] == '0) ? -1 : findTag(a);
    bit expHit = (idx >= 0);
    logic [DATA_W-1:0] expD = expHit ? mDat[idx] : '0;
    string req = expHit ? ((idx == ord[0]) ? "R6" : "R7") : "R7";
    if (expHit && idx != ord[0]) touch(idx);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    #1;
    check(loadHit == expHit, req, "loadHit", 64'(loadHit), 64'(expHit));
    if (expHit && loadHit)
      check(loadData == expD, req, "loadData", 64'(loadData), 64'(expD));
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    doReset();
    // R1 empty buffer: nothing hits
    doLoad(16'h0011);
    doLoad(16'h8001);
    for (int v = 0; v < NV; v++) begin
      case (VECS[v].op)
        2'd0: doLoad(VECS[v].addr);
        2'd1: doStore(VECS[v].addr, VECS[v].data);
        default: doReset();
      endcase
    end
    // directed: R3 rewrite of the newest entry keeps its order, no stall
    doStore(16'h0031, 50'h3_1234_5678_9ABC);
    doLoad(16'h0031);
    // directed: R2 dropped stores leave the drain count alone (R10)
    doStore(16'h8004, 50'h0);
    doStore(16'h0000, 50'h0);
    doStore(16'h8004, 50'h0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule